// File: doc/BRIEF.md
# Unique Identifier Readout Register Block

This block exposes a small per-device identifier of four 32-bit words to software. The words are never mapped into the address space directly. Software writes a control register whose upper half holds a byte offset into the identifier. If none of the lock-operation bits is set, the addressed word is copied into a separate read-key register, and software then reads it from there.

The identifier reaches the block on a 128-bit input bus. The bus is sampled in the cycle of the control write. Register access uses a plain 32-bit slave port with separate read and write strobes over a 1 KiB window. Read data is registered and is valid one cycle after the read strobe. Reset is synchronous and active-low.

Top module: `uid_readout`

## Requirements
- R1: After reset the control register, the read-key register and the read data output are all zero.
- R2: A write to byte offset 0x40 stores the write data in the control register with bit 1 forced to 0, and a read of 0x40 returns that stored value.
- R3: When the stored control value has none of the bits in mask 0xAC set (bits 7, 5, 3, 2), the word index is control bits [31:16] divided by 4. If that index is below 4, the read-key register (offset 0x60) is loaded with identifier word `index`, where word k is input bits [32k+31:32k].
- R4: When the index from R3 is 4 or more, a control write leaves the read-key register unchanged.
- R5: When any bit of mask 0xAC is set in the stored control value, a control write still updates the control register but leaves the read-key register unchanged.
- R6: A write to offset 0x60 changes neither the read-key register nor the control register.
- R7: The full 10-bit address is compared, so only 0x40 and 0x60 are registers. A read of any other address, including an unaligned one such as 0x41, returns zero, and a write to such an address changes no register.
- R8: Read data appears one cycle after the read strobe and holds its value in cycles without a read. A write to the control register is visible to a read strobe issued in the next cycle.
- R9: The read-key register takes the identifier value present in the cycle of the control write. Later changes on the identifier input do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_addr | input | 10 | Byte address within the window |
| acc_wr | input | 1 | Write strobe, one access per cycle |
| acc_rd | input | 1 | Read strobe |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Registered read data |
| id_bus | input | 128 | Identifier words, word 0 in bits [31:0] |

## Verification
The assertions assume that the read and write strobes are never high together, and that the identifier bus is a plain level whose value counts only at the control write edge. The bench drives each strobe for exactly one cycle from its own tasks and never overlaps them. It also changes the identifier words only between accesses, so every expected key is the value present at the write edge. Addresses outside the two registers are taken from a fixed list that includes unaligned and out-of-range-looking values, all inside the 10-bit space.

// File: rtl/uid_pkg.sv
package uid_pkg;
  localparam int unsigned UID_WORD_W = 32;
  localparam int unsigned UID_IDX_W  = 16;

  typedef logic [UID_WORD_W-1:0] uid_word_t;

  // Value retained by the control register after a write.
  function automatic uid_word_t uid_store_value(input uid_word_t wdata,
                                                input uid_word_t clr_mask);
    return wdata & ~clr_mask;
  endfunction

  // True when any lock-operation bit is present.
  function automatic logic uid_is_locked(input uid_word_t ctrl,
                                         input uid_word_t lock_mask);
    return (ctrl & lock_mask) != '0;
  endfunction

  // Upper half is a byte offset; convert it to a word index.
  function automatic logic [UID_IDX_W-1:0] uid_word_index(input uid_word_t ctrl);
    return ctrl[UID_WORD_W-1:UID_WORD_W-UID_IDX_W] >> 2;
  endfunction
endpackage

// File: rtl/uid_addr_decode.sv
module uid_addr_decode #(
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned CTRL_OFS = 'h40,
  parameter int unsigned KEY_OFS  = 'h60
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic              wr_ctrl,
  output logic              rd_ctrl,
  output logic              rd_key
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] KEY_A  = ADDR_W'(KEY_OFS);

  logic is_ctrl, is_key;

  always_comb begin
    is_ctrl = (addr == CTRL_A);
    is_key  = (addr == KEY_A);
    wr_ctrl = wr & is_ctrl;
    rd_ctrl = rd & is_ctrl;
    rd_key  = rd & is_key;
  end
endmodule

// File: rtl/uid_ctrl_reg.sv
module uid_ctrl_reg
  import uid_pkg::*;
#(
  parameter int unsigned CLR_MASK  = 'h2,
  parameter int unsigned LOCK_MASK = 'hAC
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_ctrl,
  input  uid_word_t            wdata,
  output uid_word_t            ctrl_q,
  output logic                 load_req,
  output logic [UID_IDX_W-1:0] load_idx
);
  localparam uid_word_t CLR_M  = UID_WORD_W'(CLR_MASK);
  localparam uid_word_t LOCK_M = UID_WORD_W'(LOCK_MASK);

  uid_word_t next_ctrl;

  always_comb begin
    next_ctrl = uid_store_value(wdata, CLR_M);
    load_req  = wr_ctrl & ~uid_is_locked(next_ctrl, LOCK_M);
    load_idx  = uid_word_index(next_ctrl);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= next_ctrl;
  end
endmodule

// File: rtl/uid_key_latch.sv
module uid_key_latch
  import uid_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            load_req,
  input  logic [UID_IDX_W-1:0]            load_idx,
  input  logic [NUM_WORDS*UID_WORD_W-1:0] id_bus,
  output logic                            key_load,
  output uid_word_t                       key_q
);
  localparam int unsigned SEL_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  uid_word_t word_arr [NUM_WORDS];
  uid_word_t picked;
  logic      in_range;

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_words
    assign word_arr[g] = id_bus[g*UID_WORD_W +: UID_WORD_W];
  end

  always_comb begin
    in_range = ({16'd0, load_idx} < NUM_WORDS);
    key_load = load_req & in_range;
    picked   = word_arr[load_idx[SEL_W-1:0]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        key_q <= '0;
    else if (key_load) key_q <= picked;
  end
endmodule

// File: rtl/uid_rdata_mux.sv
module uid_rdata_mux
  import uid_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rd,
  input  logic      rd_ctrl,
  input  logic      rd_key,
  input  uid_word_t ctrl_q,
  input  uid_word_t key_q,
  output uid_word_t rdata
);
  uid_word_t sel;

  always_comb begin
    sel = '0;
    if (rd_ctrl)     sel = ctrl_q;
    else if (rd_key) sel = key_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= sel;
  end
endmodule

// File: rtl/uid_readout.sv
module uid_readout
  import uid_pkg::*;
#(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned NUM_WORDS = 4,
  parameter int unsigned CTRL_OFS  = 'h40,
  parameter int unsigned KEY_OFS   = 'h60,
  parameter int unsigned CLR_MASK  = 'h2,
  parameter int unsigned LOCK_MASK = 'hAC
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [ADDR_W-1:0]               acc_addr,
  input  logic                            acc_wr,
  input  logic                            acc_rd,
  input  logic [31:0]                     acc_wdata,
  output logic [31:0]                     acc_rdata,
  input  logic [NUM_WORDS*UID_WORD_W-1:0] id_bus
);
  // Named internal events, visible to the bound checker.
  logic                 wr_ctrl, rd_ctrl, rd_key;
  logic                 load_req, key_load;
  logic [UID_IDX_W-1:0] load_idx;
  uid_word_t            ctrl_q, key_q;

  uid_addr_decode #(.ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .KEY_OFS(KEY_OFS)) u_dec (
    .addr(acc_addr), .wr(acc_wr), .rd(acc_rd),
    .wr_ctrl(wr_ctrl), .rd_ctrl(rd_ctrl), .rd_key(rd_key)
  );

  uid_ctrl_reg #(.CLR_MASK(CLR_MASK), .LOCK_MASK(LOCK_MASK)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wdata(acc_wdata),
    .ctrl_q(ctrl_q), .load_req(load_req), .load_idx(load_idx)
  );

  uid_key_latch #(.NUM_WORDS(NUM_WORDS)) u_key (
    .clk(clk), .rst_n(rst_n), .load_req(load_req), .load_idx(load_idx),
    .id_bus(id_bus), .key_load(key_load), .key_q(key_q)
  );

  uid_rdata_mux u_rd (
    .clk(clk), .rst_n(rst_n), .rd(acc_rd), .rd_ctrl(rd_ctrl), .rd_key(rd_key),
    .ctrl_q(ctrl_q), .key_q(key_q), .rdata(acc_rdata)
  );
endmodule

// File: rtl/uid_readout_chk.sv
module uid_readout_chk #(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned NUM_WORDS = 4,
  parameter int unsigned CTRL_OFS  = 'h40,
  parameter int unsigned KEY_OFS   = 'h60,
  parameter int unsigned LOCK_MASK = 'hAC
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [ADDR_W-1:0]      acc_addr,
  input logic                   acc_wr,
  input logic                   acc_rd,
  input logic [31:0]            acc_wdata,
  input logic [31:0]            acc_rdata,
  input logic [NUM_WORDS*32-1:0] id_bus,
  input logic [31:0]            ctrl_q,
  input logic [31:0]            key_q
);
  logic at_ctrl, at_key, locked_w, fits_w;
  logic [31:0] want_word;

  always_comb begin
    at_ctrl   = acc_addr == ADDR_W'(CTRL_OFS);
    at_key    = acc_addr == ADDR_W'(KEY_OFS);
    locked_w  = |(acc_wdata & 32'(LOCK_MASK));
    fits_w    = (32'(acc_wdata[31:16]) / 4) < NUM_WORDS;
    want_word = 32'(id_bus >> (32 * (32'(acc_wdata[31:16]) / 4)));
  end

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (acc_rdata == 32'd0 && ctrl_q == 32'd0 && key_q == 32'd0));

  a_r2_bit1_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[1] == 1'b0);

  a_r3_key_load: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && at_ctrl && !locked_w && fits_w) |=> key_q == $past(want_word));

  a_r4_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && at_ctrl && !fits_w) |=> $stable(key_q));

  a_r5_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && at_ctrl && locked_w) |=> $stable(key_q));

  a_r6_key_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && at_key) |=> ($stable(key_q) && $stable(ctrl_q)));

  a_r7_other_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && !at_ctrl && !at_key) |=> acc_rdata == 32'd0);

  a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_rd |=> $stable(acc_rdata));
endmodule

bind uid_readout uid_readout_chk #(
  .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .CTRL_OFS(CTRL_OFS),
  .KEY_OFS(KEY_OFS), .LOCK_MASK(LOCK_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_wr(acc_wr),
  .acc_rd(acc_rd), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
  .id_bus(id_bus), .ctrl_q(ctrl_q), .key_q(key_q)
);

// File: tb/uid_readout_test.sv
module uid_readout_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [9:0]   acc_addr = '0;
  logic         acc_wr = 1'b0;
  logic         acc_rd = 1'b0;
  logic [31:0]  acc_wdata = '0;
  logic [31:0]  acc_rdata;
  logic [127:0] id_bus = '0;

  int n_checks = 0;
  int n_errors = 0;
  logic [31:0] model_key = '0;
  logic [31:0] model_ctrl = '0;
  logic [31:0] got;

  always #2 clk = ~clk;

  uid_readout uut (
    .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_wr(acc_wr),
    .acc_rd(acc_rd), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .id_bus(id_bus)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    acc_addr = a; acc_wdata = d; acc_wr = 1'b1;
    @(negedge clk);
    acc_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    acc_addr = a; acc_rd = 1'b1;
    @(negedge clk);
    acc_rd = 1'b0;
    d = acc_rdata;
  endtask

  function automatic logic [31:0] word_of(input logic [127:0] b, input int k);
    return b[k*32 +: 32];
  endfunction

  // Reference model for a control write, written from the requirements.
  task automatic model_ctrl_write(input logic [31:0] d);
    int byte_ofs;
    model_ctrl = {d[31:2], 1'b0, d[0]};
    byte_ofs = int'(model_ctrl[31:16]);
    if ((model_ctrl & 32'h0000_00AC) == 32'd0 && byte_ofs < 16)
      model_key = word_of(id_bus, byte_ofs / 4);
  endtask

  initial begin
    logic [9:0] odd_addr [6] = '{10'h000, 10'h041, 10'h044, 10'h05C, 10'h061, 10'h3FC};
    int iter = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rdata", acc_rdata, 32'd0);
    bus_read(10'h040, got); check("R1 ctrl", got, 32'd0);
    bus_read(10'h060, got); check("R1 key", got, 32'd0);

    // Sweep byte offsets and every lock-bit combination.
    for (int ofs = 0; ofs < 24; ofs++) begin
      for (int lk = 0; lk < 16; lk++) begin
        logic [31:0] d;
        iter++;
        id_bus = {32'hA000_0000 + 32'(iter), 32'hB100_0000 + 32'(iter),
                  32'hC200_0000 + 32'(iter), 32'hD300_0000 + 32'(iter)};
        d = {16'(ofs), 8'(lk[0] << 2 | lk[1] << 3 | lk[2] << 5 | lk[3] << 7), 8'd0}
            | {24'd0, 8'(lk[0] << 2 | lk[1] << 3 | lk[2] << 5 | lk[3] << 7)}
            | 32'h0000_0013;
        d[15:8] = 8'(iter);
        bus_write(10'h040, d);
        model_ctrl_write(d);
        bus_read(10'h060, got);
        if (lk != 0)        check("R5 locked key", got, model_key);
        else if (ofs >= 16) check("R4 range key", got, model_key);
        else                check("R3 key load", got, model_key);
        bus_read(10'h040, got);
        check("R2 ctrl readback", got, model_ctrl);
      end
    end

    // R9: identifier change after the write does not reach the key.
    id_bus = {32'h1111_1111, 32'h2222_2222, 32'h3333_3333, 32'h4444_4444};
    bus_write(10'h040, 32'h0008_0000);
    model_ctrl_write(32'h0008_0000);
    id_bus = ~id_bus;
    bus_read(10'h060, got); check("R9 sampled id", got, 32'h2222_2222);

    // R6: writing the key offset is ignored.
    bus_write(10'h060, 32'hDEAD_BEEF);
    bus_read(10'h060, got); check("R6 key after write", got, model_key);
    bus_read(10'h040, got); check("R6 ctrl after write", got, model_ctrl);

    // R7: other offsets read zero and writes do nothing.
    for (int i = 0; i < 6; i++) begin
      bus_write(odd_addr[i], 32'h0004_0000);
      bus_read(odd_addr[i], got); check("R7 other read", got, 32'd0);
      bus_read(10'h060, got); check("R7 key unchanged", got, model_key);
      bus_read(10'h040, got); check("R7 ctrl unchanged", got, model_ctrl);
    end

    // R8: write then an immediate read; rdata holds through idle cycles.
    bus_write(10'h040, 32'h0000_0002);
    model_ctrl_write(32'h0000_0002);
    bus_read(10'h060, got); check("R8 next-cycle key", got, model_key);
    repeat (3) @(negedge clk);
    check("R8 rdata hold", acc_rdata, model_key);

    // R1: reset in mid-run clears both registers.
    bus_write(10'h040, 32'h0004_0001);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R1 rdata after reset", acc_rdata, 32'd0);
    bus_read(10'h040, got); check("R1 ctrl after reset", got, 32'd0);
    bus_read(10'h060, got); check("R1 key after reset", got, 32'd0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule